// File: doc/BRIEF.md
# Flash Floating-Code Update Engine

This block stores K logical bits (K even) in a bank of G groups of K multi-level cells, each holding a charge level from 0 to Q-1. It models flash behaviour: a cell level can only go up, and the only way down is an erase of the whole bank. Each update toggles one logical bit by raising exactly one cell by one level. The read port rebuilds all K bits from the cell levels alone. No per-bit bookkeeping is stored anywhere.

A group belongs to at most one bit. Which bit it holds is found from the position of its fill front. The bit's value is the parity of the group's total charge. A bit j fills its group starting at cell j. When a cell reaches Q-1, filling moves one cell to the right and wraps from the last cell to the first. Once no legal increment is left, the engine rejects the update and raises `reset_needed` until the bank is erased.

The control is a two-state machine. In `ST_RUN` updates are accepted. In `ST_HALT` the bank is frozen. There are two transitions:
- `T_REJECT` (`ST_RUN` to `ST_HALT`): taken on an accepted update that cannot be stored.
- `T_ERASE` (`ST_HALT` to `ST_RUN`): taken on `erase`.

Every other cycle the machine stays in its current state.

Top module: `fc_engine`

## Requirements
- R1: After `rst_n` low, or in the cycle after `erase` is high, every cell is 0, `rd_bits` is all zeros, `reset_needed` is 0, and `upd_ready` is 1 once `erase` is low.
- R2: An update is taken only in a cycle with `upd_valid` and `upd_ready` both high. `upd_ready` is high exactly when the engine is in `ST_RUN` and `erase` is low. The new value shows on `rd_bits` from the cycle after acceptance. Cycles without an accepted update change no cell.
- R3: An accepted update that is not rejected inverts `rd_bits[upd_bit]` and leaves every other bit of `rd_bits` unchanged.
- R4: Bit j (0-based) reads the parity of the summed levels of the one live group that decodes to j, or 0 if there is none. A group decodes as follows:
  - If it contains a level-0 cell, it decodes to j, where cell j is the nonzero cell that cyclically follows a zero cell.
  - Otherwise it decodes to j, where cell j-1 (mod K) is its only cell below Q-1.
  - All-zero groups and all-full groups decode to no bit.
  An update raises exactly one cell by exactly one level, and no level ever decreases except by erase.
- R5: An owned bit j raises the first cell below Q-1 in the cyclic order j, j+1, ..., K-1, 0, ..., j-1. The read value stays correct across the wrap from the last cell back to the first.
- R6: A bit that owns no group claims the all-zero group with the lowest index, and cell j of that group is set to 1. The K*(Q-1)-th increment of a group completes it (all cells at Q-1). The group is then retired, and because K is even the bit reads 0 with no group. Its next toggle claims a new group.
- R7: An accepted update of a bit that owns no group, when no all-zero group is left, changes no cell and leaves `rd_bits` unchanged (`T_REJECT`). `reset_needed` reads 1 from the next cycle.
- R8: While `reset_needed` is 1, `upd_ready` is 0, and cells and `rd_bits` stay unchanged until `erase`.
- R9: `erase` takes priority over a simultaneous `upd_valid`: the update is not taken, and the bank is cleared (`T_ERASE` when halted).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| erase | input | 1 | Synchronous bank erase, clears every cell |
| upd_valid | input | 1 | Update request |
| upd_ready | output | 1 | Engine can take an update this cycle |
| upd_bit | input | $clog2(K) | Index of the bit to toggle |
| rd_bits | output | K | Decoded values of all logical bits |
| reset_needed | output | 1 | Bank is exhausted and must be erased |

## Verification
The bench drives one bit through a whole group, which makes its fill front wrap from the last cell to the first. A design that follows the fill front the wrong way, or that loses it at the wrap, misreads the bit or credits it to a neighbour. The bench then drives that bit to the completing increment: a design that does not retire the full group keeps two groups tied to the bit, or leaves it with the wrong value. Next it uses up every free group and toggles a bit that owns none. A design that writes anyway, or that keeps accepting updates after `reset_needed`, shows a changed `rd_bits`. A long pseudo-random run mixes idle cycles, erases and erases that arrive together with updates. This exposes errors in the lowest-free-group choice and in the decode of partly filled groups.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } fc_state_e;
endpackage

// File: rtl/fc_group_dec.sv
// Decodes one group of K cells: which bit it carries, whether it is live,
// whether it is blank, and the parity of its charge.
module fc_group_dec #(
    parameter int K  = 4,
    parameter int Q  = 4,
    parameter int LW = $clog2(Q),
    parameter int BW = $clog2(K)
) (
    input  logic [K*LW-1:0] lvl,
    output logic            live,
    output logic            blank,
    output logic [BW-1:0]   owner,
    output logic            par
);
    localparam logic [LW-1:0] TOP = LW'(Q - 1);

    logic has_zero, all_zero, all_full;

    always_comb begin
        has_zero = 1'b0;
        all_zero = 1'b1;
        all_full = 1'b1;
        par      = 1'b0;
        owner    = '0;
        for (int i = 0; i < K; i++) begin
            if (lvl[i*LW +: LW] == '0) has_zero = 1'b1;
            else                       all_zero = 1'b0;
            if (lvl[i*LW +: LW] != TOP) all_full = 1'b0;
            par = par ^ lvl[i*LW];
        end
        // Fill front: a zero cell followed by a charged one, or, when no
        // cell is empty, the only non-full cell; the bit sits just past it.
        for (int i = 0; i < K; i++) begin
            if (has_zero) begin
                if (lvl[i*LW +: LW] == '0 && lvl[((i + 1) % K)*LW +: LW] != '0)
                    owner = BW'((i + 1) % K);
            end else if (lvl[i*LW +: LW] != TOP) begin
                owner = BW'((i + 1) % K);
            end
        end
    end

    assign live  = !all_zero && !all_full;
    assign blank = all_zero;
endmodule

// File: rtl/fc_update_plan.sv
// Works out the cell bank after toggling one bit, or flags that it cannot.
module fc_update_plan #(
    parameter int K  = 4,
    parameter int G  = 4,
    parameter int Q  = 4,
    parameter int LW = $clog2(Q),
    parameter int BW = $clog2(K)
) (
    input  logic [G*K*LW-1:0] cells,
    input  logic [G-1:0]      live,
    input  logic [G-1:0]      blank,
    input  logic [G*BW-1:0]   owners,
    input  logic [BW-1:0]     sel,
    output logic [G*K*LW-1:0] cells_next,
    output logic              reject
);
    localparam int            GL  = K * LW;
    localparam logic [LW-1:0] TOP = LW'(Q - 1);

    logic          act_hit, free_hit, pos_hit;
    int            act_g, free_g, pos, tgt;
    logic [GL-1:0] grp;

    always_comb begin
        act_hit  = 1'b0;
        act_g    = 0;
        free_hit = 1'b0;
        free_g   = 0;
        for (int g = 0; g < G; g++) begin
            if (!act_hit && live[g] && owners[g*BW +: BW] == sel) begin
                act_hit = 1'b1;
                act_g   = g;
            end
        end
        for (int g = 0; g < G; g++) begin
            if (!free_hit && blank[g]) begin
                free_hit = 1'b1;
                free_g   = g;
            end
        end
        grp     = cells[act_g*GL +: GL];
        pos_hit = 1'b0;
        pos     = 0;
        for (int i = 0; i < K; i++) begin
            if (!pos_hit && grp[((int'(sel) + i) % K)*LW +: LW] != TOP) begin
                pos_hit = 1'b1;
                pos     = (int'(sel) + i) % K;
            end
        end
        cells_next = cells;
        reject     = 1'b0;
        tgt        = 0;
        if (act_hit) begin
            tgt = act_g * K + pos;
            cells_next[tgt*LW +: LW] = cells[tgt*LW +: LW] + LW'(1);
        end else if (free_hit) begin
            tgt = free_g * K + int'(sel);
            cells_next[tgt*LW +: LW] = LW'(1);
        end else begin
            reject = 1'b1;
        end
    end
endmodule

// File: rtl/fc_engine.sv
module fc_engine
    import fc_pkg::*;
#(
    parameter int K = 4,
    parameter int G = 4,
    parameter int Q = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 erase,
    input  logic                 upd_valid,
    output logic                 upd_ready,
    input  logic [$clog2(K)-1:0] upd_bit,
    output logic [K-1:0]         rd_bits,
    output logic                 reset_needed
);
    localparam int LW = $clog2(Q);
    localparam int BW = $clog2(K);
    localparam int GL = K * LW;
    localparam int NL = G * GL;

    fc_state_e       state_q, state_d;
    logic [NL-1:0]   cells_q, cells_d;
    logic [G-1:0]    g_live, g_blank, g_par;
    logic [G*BW-1:0] g_owner;
    logic            reject, fire;

    for (genvar g = 0; g < G; g++) begin : g_dec
        fc_group_dec #(.K(K), .Q(Q), .LW(LW), .BW(BW)) u_dec (
            .lvl   (cells_q[g*GL +: GL]),
            .live  (g_live[g]),
            .blank (g_blank[g]),
            .owner (g_owner[g*BW +: BW]),
            .par   (g_par[g])
        );
    end

    fc_update_plan #(.K(K), .G(G), .Q(Q), .LW(LW), .BW(BW)) u_plan (
        .cells      (cells_q),
        .live       (g_live),
        .blank      (g_blank),
        .owners     (g_owner),
        .sel        (upd_bit),
        .cells_next (cells_d),
        .reject     (reject)
    );

    always_comb begin
        rd_bits = '0;
        for (int j = 0; j < K; j++) begin
            for (int g = 0; g < G; g++) begin
                if (g_live[g] && g_owner[g*BW +: BW] == BW'(j))
                    rd_bits[j] = rd_bits[j] | g_par[g];
            end
        end
    end

    // Outputs of the state machine
    always_comb begin
        upd_ready    = 1'b0;
        reset_needed = 1'b0;
        unique case (state_q)
            ST_RUN:  upd_ready    = !erase;
            ST_HALT: reset_needed = 1'b1;
            default: ;
        endcase
    end

    assign fire = upd_valid && upd_ready;

    // Transitions: T_REJECT and T_ERASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (fire && reject) state_d = ST_HALT;
            ST_HALT: if (erase)          state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cells_q <= '0;
        else if (erase)            cells_q <= '0;
        else if (fire && !reject)  cells_q <= cells_d;
    end
endmodule

// File: rtl/fc_engine_chk.sv
module fc_engine_chk #(
    parameter int K = 4,
    parameter int G = 4,
    parameter int Q = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  erase,
    input logic                  upd_valid,
    input logic                  upd_ready,
    input logic                  reset_needed,
    input logic                  reject,
    input logic [K-1:0]          rd_bits,
    input logic [G*K*$clog2(Q)-1:0] cells
);
    localparam int LW = $clog2(Q);
    localparam int N  = G * K;

    logic [N*LW-1:0] prev_q;
    logic [N-1:0]    moved, lowered;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cells;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            moved[i]   = cells[i*LW +: LW] != prev_q[i*LW +: LW];
            lowered[i] = cells[i*LW +: LW] <  prev_q[i*LW +: LW];
        end
    end

    p_single_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(erase) |-> ($countones(moved) <= 1 && lowered == '0));

    for (genvar i = 0; i < N; i++) begin : g_step
        p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(erase) && moved[i]) |->
            (cells[i*LW +: LW] == prev_q[i*LW +: LW] + LW'(1)));
    end

    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(erase) && !$past(upd_valid && upd_ready)) |-> (moved == '0));

    p_reject_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_ready && reject) |=> (reset_needed && $stable(cells)));

    p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_needed && !erase) |=> ($stable(cells) && $stable(rd_bits) && reset_needed));

    p_halt_noready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_needed |-> !upd_ready);

    p_erase_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (cells == '0 && rd_bits == '0 && !reset_needed));
endmodule

bind fc_engine fc_engine_chk #(.K(K), .G(G), .Q(Q)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .erase        (erase),
    .upd_valid    (upd_valid),
    .upd_ready    (upd_ready),
    .reset_needed (reset_needed),
    .reject       (reject),
    .rd_bits      (rd_bits),
    .cells        (cells_q)
);

// File: tb/sim_fc_engine.sv
module sim_fc_engine;
    localparam int K  = 4;
    localparam int G  = 4;
    localparam int Q  = 4;
    localparam int BW = $clog2(K);

    logic          clk = 1'b0;
    logic          rst_n, erase, upd_valid;
    logic [BW-1:0] upd_bit;
    logic          upd_ready, reset_needed;
    logic [K-1:0]  rd_bits;

    always #5 clk = ~clk;

    fc_engine #(.K(K), .G(G), .Q(Q)) u0 (
        .clk(clk), .rst_n(rst_n), .erase(erase), .upd_valid(upd_valid),
        .upd_ready(upd_ready), .upd_bit(upd_bit), .rd_bits(rd_bits),
        .reset_needed(reset_needed)
    );

    // Behavioural reference: explicit ownership, fill pointers and charge.
    int lvl [G][K];
    int charge [G];
    int gstate [G];   // 0 free, 1 owned, 2 spent
    int own [K];
    int fillp [K];
    bit val [K];
    bit halt;
    int vectors = 0;
    int miscmp  = 0;

    task automatic m_clear();
        for (int g = 0; g < G; g++) begin
            charge[g] = 0;
            gstate[g] = 0;
            for (int c = 0; c < K; c++) lvl[g][c] = 0;
        end
        for (int j = 0; j < K; j++) begin
            own[j] = -1; fillp[j] = 0; val[j] = 1'b0;
        end
        halt = 1'b0;
    endtask

    task automatic m_toggle(input int b);
        int g, p;
        if (own[b] >= 0) begin
            g = own[b];
            p = fillp[b];
            lvl[g][p]++;
            charge[g]++;
            if (lvl[g][p] == Q - 1) fillp[b] = (p + 1) % K;
            val[b] = !val[b];
            if (charge[g] == K * (Q - 1)) begin
                gstate[g] = 2;
                own[b]    = -1;
            end
        end else begin
            g = -1;
            for (int h = G - 1; h >= 0; h--) if (gstate[h] == 0) g = h;
            if (g < 0) begin
                halt = 1'b1;
            end else begin
                gstate[g] = 1;
                own[b]    = g;
                lvl[g][b] = 1;
                charge[g] = 1;
                fillp[b]  = (Q - 1 == 1) ? (b + 1) % K : b;
                val[b]    = 1'b1;
            end
        end
    endtask

    function automatic logic [K-1:0] m_bits();
        logic [K-1:0] r;
        for (int j = 0; j < K; j++) r[j] = val[j];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check ready, then outputs.
    task automatic cyc(input logic v, input int b, input logic e, input string tag);
        bit exp_ready;
        upd_valid = v;
        upd_bit   = BW'(b);
        erase     = e;
        #1;
        exp_ready = !halt && !e;
        chk((e && v) ? "R9" : "R2", 32'(upd_ready), 32'(exp_ready), "upd_ready");
        @(posedge clk);
        if (e) m_clear();
        else if (v && exp_ready) m_toggle(b);
        @(negedge clk);
        chk(tag, 32'(rd_bits), 32'(m_bits()), "rd_bits");
        chk(tag, 32'(reset_needed), 32'(halt), "reset_needed");
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        bit          e_r;
        rst_n = 1'b0; erase = 1'b0; upd_valid = 1'b0; upd_bit = '0;
        m_clear();
        repeat (3) @(negedge clk);
        chk("R1", 32'(rd_bits), 32'h0, "rd_bits in reset");
        chk("R1", 32'(reset_needed), 32'h0, "reset_needed in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(upd_ready), 32'h1, "upd_ready after reset");
        cyc(1'b0, 0, 1'b0, "R1");
        // R3: independent toggles and a toggle back
        cyc(1'b1, 0, 1'b0, "R3");
        cyc(1'b1, 2, 1'b0, "R3");
        cyc(1'b1, 0, 1'b0, "R3");
        cyc(1'b0, 1, 1'b0, "R2");
        // R5: bit 1 walks its whole group, wrapping past the last cell
        for (int i = 0; i < K * (Q - 1) - 1; i++) cyc(1'b1, 1, 1'b0, "R5");
        // R6: completing increment retires the group, next toggle re-claims
        cyc(1'b1, 1, 1'b0, "R6");
        cyc(1'b1, 1, 1'b0, "R6");
        // R7: every group now taken or spent; an unowned bit is rejected
        cyc(1'b1, 3, 1'b0, "R7");
        // R8: frozen while halted
        cyc(1'b1, 0, 1'b0, "R8");
        cyc(1'b1, 2, 1'b0, "R8");
        // R9: erase beats a pending update and leaves the halt
        cyc(1'b1, 0, 1'b1, "R9");
        cyc(1'b1, 3, 1'b0, "R1");
        // R4: pseudo-random mix of updates, idles and erases
        lfsr = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            e_r  = halt ? (lfsr[3:0] == 4'h0) : (lfsr[9:2] == 8'hFF);
            cyc(lfsr[5] | lfsr[6], int'(lfsr[9:8]) % K, e_r, "R4");
        end
        summary();
        $finish;
    end
endmodule